// File: doc/BRIEF.md
# Outbound Config Address Translator

This block sits on the CPU side of a PCIe root port. It turns each lookup into a translated target address and a transaction type code. A lookup is either a plain access with a 64-bit CPU address or a configuration access named by bus, device, function and register offset. Software sets up a small file of outbound translation windows. It first writes a viewport register that picks one window. It then reads and writes that window's control, base, limit and target words at fixed offsets.

A plain access is matched against every enabled window. Each window compares the upper 32 address bits for equality and the lower 32 bits against an inclusive base/limit range. The lowest-numbered matching window supplies the type code and the target, which is the window's target plus the distance of the address from the window's base. Configuration accesses follow different rules:
- Bus 0 addresses the root port's own registers, so the request is flagged local and is not translated.
- Every other bus goes through one dedicated window. The type is chosen from the bus number.
- The target packs the bus, device and function fields together with the word-aligned register offset.
- Device numbers that cannot exist below the root port are flagged invalid. A read to such a device is also flagged for an all-ones completion, and a write to it is simply not issued.

All lookup results are registered and appear one clock after the request.

Top module: `ob_xlat`

## Requirements
- R1: After reset every window is disabled, every register reads as zero, and `xl_valid` is 0.
- R2: Writing offset 0x900 stores bit 31 as the direction (0 outbound, 1 inbound) and the low bits as the window index. Both read back at the same positions. Offsets 0x904 (type code, bits 4:0), 0x908 (bit 31 enable, bit 30 BAR-match mode), 0x90C (lower base), 0x910 (upper base), 0x914 (limit), 0x918 (lower target) and 0x91C (upper target) write and read the selected window. Bits outside the listed fields read as zero.
- R3: While the viewport direction is inbound, writes to offsets 0x904 through 0x91C change no window, and reads of those offsets return zero.
- R4: A plain lookup hits a window when all of the following hold: the window is enabled, address bits 63:32 equal its upper base, and address bits 31:0 lie between its lower base and its limit inclusive. On a hit, `xl_kind` is the window's type code and `xl_addr` is {upper target, lower target} + (address − {upper base, lower base}).
- R5: When more than one enabled window matches, the window with the lowest index supplies the result.
- R6: A plain lookup that matches no enabled window sets `xl_miss` to 1, with `xl_addr` 0 and `xl_kind` 0. A disabled window never matches.
- R7: A configuration lookup on bus 0 with device 0 or 1 sets `xl_local` to 1 and `xl_miss` to 0, and its `xl_addr` is the register offset with bits 1:0 cleared.
- R8: A configuration lookup on bus 1 with device 0 has type 4. A configuration lookup on any bus of 2 or more has type 5. For both, `xl_addr` is {upper target of window CFG_WIN, bus in 31:24, device in 23:19, function in 18:16, zero in 15:12, the word-aligned offset in 11:0}.
- R9: A configuration lookup on bus 0 with device above 1, or on bus 1 with device above 0, sets `xl_invalid` to 1 and clears `xl_local` and `xl_miss`. `xl_rd_ones` is 1 for a read and 0 for a write.
- R10: A configuration lookup on a bus other than 0 sets `xl_miss` to 1 while window CFG_WIN is disabled. An invalid device takes precedence over the miss.
- R11: `xl_valid` is 1 in exactly the cycle after a cycle with `lk_valid` high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_is_cfg | input | 1 | 1 = configuration lookup, 0 = plain address lookup |
| lk_write | input | 1 | 1 = write, 0 = read |
| lk_addr | input | 64 | CPU address for plain lookups |
| lk_bus | input | 8 | Configuration bus number |
| lk_dev | input | 5 | Configuration device number |
| lk_func | input | 3 | Configuration function number |
| lk_off | input | 12 | Configuration register byte offset |
| xl_valid | output | 1 | Result valid, one cycle after lk_valid |
| xl_addr | output | 64 | Translated target or local register offset |
| xl_kind | output | 5 | Transaction type code |
| xl_local | output | 1 | Access is to root-port local registers |
| xl_invalid | output | 1 | Configuration device cannot exist |
| xl_rd_ones | output | 1 | Invalid read, complete with all ones |
| xl_miss | output | 1 | No enabled window serves the access |

## Verification
The assertions take two things for granted. The lookup fields are sampled only in the cycle `lk_valid` is high. `lk_valid` is held low throughout reset, so no result can be pending when reset releases. The stimulus drives every field at the falling edge and drops `lk_valid` after one cycle. It never issues a register write and a lookup in the same cycle, so each lookup sees window settings that are already stable.

// File: rtl/ob_xlat_pkg.sv
// Shared constants and the window record for the outbound translator.
// Assumes register offsets are 12-bit byte offsets inside the port's space.
package ob_xlat_pkg;
    localparam int KIND_W = 5;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FUN_W  = 3;
    localparam int OFF_W  = 12;

    localparam logic [OFF_W-1:0] OFS_VIEW  = 12'h900;
    localparam logic [OFF_W-1:0] OFS_CTL1  = 12'h904;
    localparam logic [OFF_W-1:0] OFS_CTL2  = 12'h908;
    localparam logic [OFF_W-1:0] OFS_LBASE = 12'h90C;
    localparam logic [OFF_W-1:0] OFS_UBASE = 12'h910;
    localparam logic [OFF_W-1:0] OFS_LIMIT = 12'h914;
    localparam logic [OFF_W-1:0] OFS_LTGT  = 12'h918;
    localparam logic [OFF_W-1:0] OFS_UTGT  = 12'h91C;

    localparam logic [KIND_W-1:0] KIND_MEM  = 5'd0;
    localparam logic [KIND_W-1:0] KIND_IO   = 5'd2;
    localparam logic [KIND_W-1:0] KIND_CFG0 = 5'd4;
    localparam logic [KIND_W-1:0] KIND_CFG1 = 5'd5;

    typedef struct packed {
        logic              en;
        logic              bar;
        logic [KIND_W-1:0] kind;
        logic [31:0]       lbase;
        logic [31:0]       ubase;
        logic [31:0]       limit;
        logic [31:0]       ltgt;
        logic [31:0]       utgt;
    } win_t;
endpackage

// File: rtl/ob_xlat_regs.sv
// Viewport-indexed register file holding NWIN outbound windows.
// Assumes NWIN >= 1; an index at or above NWIN, or an inbound viewport,
// selects no storage: writes are ignored and reads return zero.
module ob_xlat_regs
    import ob_xlat_pkg::*;
#(
    parameter  int NWIN = 4,
    localparam int IW   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [OFF_W-1:0]       addr,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    output win_t [NWIN-1:0]        wins
);
    logic          vp_in;
    logic [IW-1:0] vp_idx;
    win_t [NWIN-1:0] win_q;
    logic          sel_ok;
    win_t          cur;

    // Selected window is usable only for an outbound, in-range index.
    assign sel_ok = !vp_in && (32'(vp_idx) < NWIN);

    // Viewport and window storage updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vp_in  <= 1'b0;
            vp_idx <= '0;
            win_q  <= '0;
        end else if (wr) begin
            if (addr == OFS_VIEW) begin
                vp_in  <= wdata[31];
                vp_idx <= wdata[IW-1:0];
            end else if (sel_ok) begin
                case (addr)
                    OFS_CTL1:  win_q[vp_idx].kind  <= wdata[KIND_W-1:0];
                    OFS_CTL2: begin
                        win_q[vp_idx].en  <= wdata[31];
                        win_q[vp_idx].bar <= wdata[30];
                    end
                    OFS_LBASE: win_q[vp_idx].lbase <= wdata;
                    OFS_UBASE: win_q[vp_idx].ubase <= wdata;
                    OFS_LIMIT: win_q[vp_idx].limit <= wdata;
                    OFS_LTGT:  win_q[vp_idx].ltgt  <= wdata;
                    OFS_UTGT:  win_q[vp_idx].utgt  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // Read-back mux for the offset currently presented.
    always_comb begin
        cur   = sel_ok ? win_q[vp_idx] : '0;
        rdata = '0;
        case (addr)
            OFS_VIEW: begin
                rdata[31]     = vp_in;
                rdata[IW-1:0] = vp_idx;
            end
            OFS_CTL1:  rdata[KIND_W-1:0] = cur.kind;
            OFS_CTL2: begin
                rdata[31] = cur.en;
                rdata[30] = cur.bar;
            end
            OFS_LBASE: rdata = cur.lbase;
            OFS_UBASE: rdata = cur.ubase;
            OFS_LIMIT: rdata = cur.limit;
            OFS_LTGT:  rdata = cur.ltgt;
            OFS_UTGT:  rdata = cur.utgt;
            default:   rdata = '0;
        endcase
    end

    assign wins = win_q;
endmodule

// File: rtl/ob_xlat_match.sv
// Priority matcher for plain address lookups across all windows.
// Assumes the window record is stable during the lookup cycle; the
// lowest-index enabled window whose range holds the address wins.
module ob_xlat_match
    import ob_xlat_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  win_t [NWIN-1:0]   wins,
    input  logic [63:0]       addr,
    output logic              hit,
    output logic [KIND_W-1:0] kind,
    output logic [63:0]       tgt
);
    logic [NWIN-1:0] inwin;
    logic [63:0]     moved [NWIN];

    // One range comparator and offset adder per window.
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        assign inwin[g] = wins[g].en
                        && (addr[63:32] == wins[g].ubase)
                        && (addr[31:0] >= wins[g].lbase)
                        && (addr[31:0] <= wins[g].limit);
        assign moved[g] = {wins[g].utgt, wins[g].ltgt}
                        + (addr - {wins[g].ubase, wins[g].lbase});
    end

    // Scan high to low so the lowest matching index is assigned last.
    always_comb begin
        hit  = 1'b0;
        kind = '0;
        tgt  = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (inwin[i]) begin
                hit  = 1'b1;
                kind = wins[i].kind;
                tgt  = moved[i];
            end
        end
    end
endmodule

// File: rtl/ob_xlat_cfg.sv
// Configuration lookup former: validity rule, local detection, type choice
// by bus number and target packing through the configuration window.
// Assumes the caller passes the window reserved for configuration traffic.
module ob_xlat_cfg
    import ob_xlat_pkg::*;
(
    input  win_t              cw,
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [FUN_W-1:0]  func,
    input  logic [OFF_W-1:0]  off,
    output logic              bad,
    output logic              local_acc,
    output logic              miss,
    output logic [KIND_W-1:0] kind,
    output logic [63:0]       tgt
);
    logic [OFF_W-1:0] aoff;

    // Word-aligned register offset.
    assign aoff = {off[OFF_W-1:2], 2'b00};

    // Classify the request and build its target.
    always_comb begin
        bad       = ((bus == 8'd0) && (dev > 5'd1)) ||
                    ((bus == 8'd1) && (dev != 5'd0));
        local_acc = !bad && (bus == 8'd0);
        miss      = !bad && !local_acc && !cw.en;
        kind      = (bus < 8'd2) ? KIND_CFG0 : KIND_CFG1;
        if (local_acc)
            tgt = {52'd0, aoff};
        else
            tgt = {cw.utgt, bus, dev, func, 4'b0000, aoff};
    end
endmodule

// File: rtl/ob_xlat.sv
// Outbound address translator top: register file, plain-address matcher
// and configuration former, with one registered result stage.
// Assumes lookup fields are meaningful only while lk_valid is high.
module ob_xlat
    import ob_xlat_pkg::*;
#(
    parameter int NWIN    = 4,
    parameter int CFG_WIN = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lk_valid,
    input  logic              lk_is_cfg,
    input  logic              lk_write,
    input  logic [63:0]       lk_addr,
    input  logic [7:0]        lk_bus,
    input  logic [4:0]        lk_dev,
    input  logic [2:0]        lk_func,
    input  logic [11:0]       lk_off,
    output logic              xl_valid,
    output logic [63:0]       xl_addr,
    output logic [4:0]        xl_kind,
    output logic              xl_local,
    output logic              xl_invalid,
    output logic              xl_rd_ones,
    output logic              xl_miss
);
    win_t [NWIN-1:0]   wins;
    logic              m_hit;
    logic [KIND_W-1:0] m_kind;
    logic [63:0]       m_tgt;
    logic              c_bad, c_local, c_miss;
    logic [KIND_W-1:0] c_kind;
    logic [63:0]       c_tgt;

    ob_xlat_regs #(.NWIN(NWIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .wins(wins)
    );

    ob_xlat_match #(.NWIN(NWIN)) u_match (
        .wins(wins), .addr(lk_addr), .hit(m_hit), .kind(m_kind), .tgt(m_tgt)
    );

    ob_xlat_cfg u_cfg (
        .cw(wins[CFG_WIN]), .bus(lk_bus), .dev(lk_dev), .func(lk_func),
        .off(lk_off), .bad(c_bad), .local_acc(c_local), .miss(c_miss),
        .kind(c_kind), .tgt(c_tgt)
    );

    // Result register: pick the path for the lookup kind and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_valid   <= 1'b0;
            xl_addr    <= '0;
            xl_kind    <= '0;
            xl_local   <= 1'b0;
            xl_invalid <= 1'b0;
            xl_rd_ones <= 1'b0;
            xl_miss    <= 1'b0;
        end else begin
            xl_valid <= lk_valid;
            if (lk_valid) begin
                if (lk_is_cfg) begin
                    xl_addr    <= c_tgt;
                    xl_kind    <= c_kind;
                    xl_local   <= c_local;
                    xl_invalid <= c_bad;
                    xl_rd_ones <= c_bad && !lk_write;
                    xl_miss    <= c_miss;
                end else begin
                    xl_addr    <= m_hit ? m_tgt : 64'd0;
                    xl_kind    <= m_hit ? m_kind : KIND_MEM;
                    xl_local   <= 1'b0;
                    xl_invalid <= 1'b0;
                    xl_rd_ones <= 1'b0;
                    xl_miss    <= !m_hit;
                end
            end
        end
    end
endmodule

// File: rtl/ob_xlat_chk.sv
// Property checker for ob_xlat, attached by bind below.
// Assumes lk_valid is low while rst_n is low.
module ob_xlat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic        lk_is_cfg,
    input logic        lk_write,
    input logic [7:0]  lk_bus,
    input logic [4:0]  lk_dev,
    input logic        xl_valid,
    input logic [63:0] xl_addr,
    input logic [4:0]  xl_kind,
    input logic        xl_local,
    input logic        xl_invalid,
    input logic        xl_rd_ones,
    input logic        xl_miss
);
    // R11: a request yields a result next cycle.
    p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> xl_valid);

    // R11: no request, no result next cycle.
    p_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !xl_valid);

    // R9: impossible device on bus 0 or 1 is flagged.
    p_bad_dev_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_is_cfg &&
         (((lk_bus == 8'd0) && (lk_dev > 5'd1)) ||
          ((lk_bus == 8'd1) && (lk_dev != 5'd0)))) |=> xl_invalid);

    // R9: all-ones completion only for an invalid read.
    p_ones_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_is_cfg && lk_write) |=> !xl_rd_ones);

    // R9: outcome flags are mutually exclusive.
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid |-> $onehot0({xl_local, xl_invalid, xl_miss}));

    // R8: valid config on bus 2 or above uses type 5.
    p_cfg1_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_is_cfg && (lk_bus >= 8'd2)) |=> (xl_kind == 5'd5));

    // R7: local accesses carry a word-aligned offset only.
    p_local_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid && xl_local) |-> ((xl_addr[1:0] == 2'b00) &&
                                    (xl_addr[63:12] == 52'd0)));

    // R6: a miss reports a zero address on plain lookups.
    p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_is_cfg) |=> (!xl_miss || (xl_addr == 64'd0)));
endmodule

bind ob_xlat ob_xlat_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_is_cfg(lk_is_cfg),
    .lk_write(lk_write), .lk_bus(lk_bus), .lk_dev(lk_dev),
    .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_kind(xl_kind),
    .xl_local(xl_local), .xl_invalid(xl_invalid), .xl_rd_ones(xl_rd_ones),
    .xl_miss(xl_miss)
);

// File: tb/sim_ob_xlat.sv
// Directed bench for ob_xlat: one task per scenario, each checking itself.
module sim_ob_xlat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic        lk_is_cfg = 1'b0;
    logic        lk_write = 1'b0;
    logic [63:0] lk_addr = '0;
    logic [7:0]  lk_bus = '0;
    logic [4:0]  lk_dev = '0;
    logic [2:0]  lk_func = '0;
    logic [11:0] lk_off = '0;
    logic        xl_valid;
    logic [63:0] xl_addr;
    logic [4:0]  xl_kind;
    logic        xl_local, xl_invalid, xl_rd_ones, xl_miss;

    int n_chk = 0;
    int n_bad = 0;

    // Captured result of the last lookup.
    logic [63:0] r_addr;
    logic [4:0]  r_kind;
    logic        r_local, r_inv, r_ones, r_miss;

    ob_xlat u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_is_cfg(lk_is_cfg), .lk_write(lk_write), .lk_addr(lk_addr),
        .lk_bus(lk_bus), .lk_dev(lk_dev), .lk_func(lk_func), .lk_off(lk_off),
        .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_kind(xl_kind),
        .xl_local(xl_local), .xl_invalid(xl_invalid),
        .xl_rd_ones(xl_rd_ones), .xl_miss(xl_miss)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a,
                          input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic lookup(input logic cfg, input logic w, input logic [63:0] a,
                          input logic [7:0] b, input logic [4:0] d,
                          input logic [2:0] f, input logic [11:0] o);
        lk_is_cfg = cfg;
        lk_write  = w;
        lk_addr   = a;
        lk_bus    = b;
        lk_dev    = d;
        lk_func   = f;
        lk_off    = o;
        lk_valid  = 1'b1;
        @(negedge clk);
        chk("R11 valid after request", 64'(xl_valid), 64'd1);
        r_addr  = xl_addr;
        r_kind  = xl_kind;
        r_local = xl_local;
        r_inv   = xl_invalid;
        r_ones  = xl_rd_ones;
        r_miss  = xl_miss;
        lk_valid = 1'b0;
        @(negedge clk);
        chk("R11 valid drops", 64'(xl_valid), 64'd0);
    endtask

    task automatic t_reset;
        chk("R1 xl_valid at reset", 64'(xl_valid), 64'd0);
        rd_chk("R1 viewport zero", 12'h900, 32'h0);
        rd_chk("R1 ctl2 zero", 12'h908, 32'h0);
        rd_chk("R1 limit zero", 12'h914, 32'h0);
        lookup(1'b0, 1'b0, 64'h0, 8'd0, 5'd0, 3'd0, 12'd0);
        chk("R1 disabled window misses", 64'(r_miss), 64'd1);
    endtask

    task automatic t_regs;
        wr(12'h900, 32'hFFFF_FFFF);
        rd_chk("R2 viewport readback", 12'h900, 32'h8000_0003);
        wr(12'h900, 32'h0000_0001);
        wr(12'h904, 32'hFFFF_FFFF);
        rd_chk("R2 ctl1 field", 12'h904, 32'h0000_001F);
        wr(12'h908, 32'hFFFF_FFFF);
        rd_chk("R2 ctl2 fields", 12'h908, 32'hC000_0000);
        wr(12'h91C, 32'h1234_5678);
        rd_chk("R2 upper target", 12'h91C, 32'h1234_5678);
        wr(12'h900, 32'h0000_0002);
        rd_chk("R2 other window untouched", 12'h91C, 32'h0);
    endtask

    task automatic t_inbound;
        wr(12'h900, 32'h0000_0001);
        wr(12'h90C, 32'h0000_AAAA);
        wr(12'h900, 32'h8000_0001);
        wr(12'h90C, 32'h0000_5555);
        rd_chk("R3 inbound reads zero", 12'h90C, 32'h0);
        wr(12'h900, 32'h0000_0001);
        rd_chk("R3 inbound write ignored", 12'h90C, 32'h0000_AAAA);
    endtask

    task automatic t_mem;
        wr(12'h900, 32'h1);
        wr(12'h904, 32'h2);
        wr(12'h908, 32'h8000_0000);
        wr(12'h90C, 32'h1000_0000);
        wr(12'h910, 32'h0);
        wr(12'h914, 32'h100F_FFFF);
        wr(12'h918, 32'h0);
        wr(12'h91C, 32'h2);
        lookup(1'b0, 1'b0, 64'h1000_0000, 8'd0, 5'd0, 3'd0, 12'd0);
        chk("R4 base addr", r_addr, 64'h2_0000_0000);
        chk("R4 type", 64'(r_kind), 64'd2);
        chk("R4 hit no miss", 64'(r_miss), 64'd0);
        lookup(1'b0, 1'b0, 64'h100F_FFFF, 8'd0, 5'd0, 3'd0, 12'd0);
        chk("R4 limit inclusive", r_addr, 64'h2_000F_FFFF);
        lookup(1'b0, 1'b0, 64'h0FFF_FFFF, 8'd0, 5'd0, 3'd0, 12'd0);
        chk("R6 below base misses", 64'(r_miss), 64'd1);
        chk("R6 miss addr zero", r_addr, 64'd0);
        lookup(1'b0, 1'b0, 64'h1_1000_0000, 8'd0, 5'd0, 3'd0, 12'd0);
        chk("R4 upper base mismatch", 64'(r_miss), 64'd1);
    endtask

    task automatic t_prio;
        wr(12'h900, 32'h2);
        wr(12'h904, 32'h0);
        wr(12'h908, 32'h8000_0000);
        wr(12'h90C, 32'h1008_0000);
        wr(12'h914, 32'h1010_0000);
        wr(12'h918, 32'h4000_0000);
        lookup(1'b0, 1'b0, 64'h1009_0000, 8'd0, 5'd0, 3'd0, 12'd0);
        chk("R5 lower index wins addr", r_addr, 64'h2_0009_0000);
        chk("R5 lower index wins type", 64'(r_kind), 64'd2);
        lookup(1'b0, 1'b0, 64'h1010_0000, 8'd0, 5'd0, 3'd0, 12'd0);
        chk("R4 second window addr", r_addr, 64'h4008_0000);
        chk("R4 second window type", 64'(r_kind), 64'd0);
        lookup(1'b0, 1'b0, 64'h1010_0001, 8'd0, 5'd0, 3'd0, 12'd0);
        chk("R6 above all limits", 64'(r_miss), 64'd1);
        wr(12'h900, 32'h1);
        wr(12'h908, 32'h0);
        lookup(1'b0, 1'b0, 64'h1009_0000, 8'd0, 5'd0, 3'd0, 12'd0);
        chk("R6 disabled window skipped", r_addr, 64'h4001_0000);
    endtask

    task automatic t_cfg;
        wr(12'h900, 32'h0);
        wr(12'h908, 32'h8000_0000);
        wr(12'h91C, 32'h0000_00AB);
        lookup(1'b1, 1'b0, 64'h0, 8'd0, 5'd1, 3'd3, 12'h013);
        chk("R7 local flag", 64'(r_local), 64'd1);
        chk("R7 local addr aligned", r_addr, 64'h10);
        chk("R7 local no miss", 64'(r_miss), 64'd0);
        lookup(1'b1, 1'b0, 64'h0, 8'd1, 5'd0, 3'd2, 12'h106);
        chk("R8 bus1 type", 64'(r_kind), 64'd4);
        chk("R8 bus1 target", r_addr, 64'h0000_00AB_0102_0104);
        lookup(1'b1, 1'b1, 64'h0, 8'd5, 5'd31, 3'd7, 12'hFFF);
        chk("R8 bus5 type", 64'(r_kind), 64'd5);
        chk("R8 bus5 target", r_addr, 64'h0000_00AB_05FF_0FFC);
        lookup(1'b1, 1'b0, 64'h0, 8'd2, 5'd0, 3'd0, 12'h0);
        chk("R8 bus2 type", 64'(r_kind), 64'd5);
    endtask

    task automatic t_invalid;
        lookup(1'b1, 1'b0, 64'h0, 8'd0, 5'd2, 3'd0, 12'h0);
        chk("R9 bus0 dev2 invalid", 64'(r_inv), 64'd1);
        chk("R9 read gets ones", 64'(r_ones), 64'd1);
        chk("R9 not local", 64'(r_local), 64'd0);
        lookup(1'b1, 1'b1, 64'h0, 8'd1, 5'd1, 3'd0, 12'h0);
        chk("R9 bus1 dev1 invalid", 64'(r_inv), 64'd1);
        chk("R9 write no ones", 64'(r_ones), 64'd0);
        lookup(1'b1, 1'b0, 64'h0, 8'd1, 5'd0, 3'd0, 12'h0);
        chk("R9 bus1 dev0 valid", 64'(r_inv), 64'd0);
    endtask

    task automatic t_cfgoff;
        wr(12'h900, 32'h0);
        wr(12'h908, 32'h0);
        lookup(1'b1, 1'b0, 64'h0, 8'd3, 5'd0, 3'd0, 12'h0);
        chk("R10 disabled cfg window miss", 64'(r_miss), 64'd1);
        lookup(1'b1, 1'b0, 64'h0, 8'd1, 5'd4, 3'd0, 12'h0);
        chk("R10 invalid beats miss", 64'(r_inv), 64'd1);
        chk("R10 no miss when invalid", 64'(r_miss), 64'd0);
        lookup(1'b1, 1'b0, 64'h0, 8'd0, 5'd0, 3'd0, 12'h8);
        chk("R10 bus0 stays local", 64'(r_local), 64'd1);
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        #4000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Scenario sequence.
    initial begin
        repeat (3) @(negedge clk);
        t_reset_during: begin
            chk("R1 xl_valid in reset", 64'(xl_valid), 64'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_inbound;
        t_mem;
        t_prio;
        t_cfg;
        t_invalid;
        t_cfgoff;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule